// File: doc/BRIEF.md
# Packed Saturating Bidirectional Lane Shifter

This block shifts every lane of a packed vector by its own signed amount. The first operand is split into lanes of 8, 16, 32 or 64 bits, chosen at run time. The lanes are signed or unsigned integers. The matching lane of the second operand supplies the shift count, in its lowest byte. A positive count shifts the lane left. If the result does not fit, the lane clamps to the nearest representable value. A zero or negative count shifts right by its magnitude and drops the bits that fall off, with no rounding.

The operation works on 64 bits or on 128 bits, and a width select picks which. For the 128-bit form the three register indices that come with the request must all be even. A request that breaks this rule is reported as undefined and produces no result. Each accepted operation returns its result one cycle after the strobe, together with a flag that says whether any lane clamped. A sticky flag gathers every clamp until a dedicated clear input is raised.

Top module: `vec_lane_qshift`

## Requirements
- R1: `lane_sz` selects the lane width: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. With `wide_sel`=1 all 128 bits are processed. With `wide_sel`=0 only bits 63:0 are processed, and bits 127:64 of the result are zero.
- R2: Each lane's shift count is bits 7:0 of the matching lane of `opnd_b`, read as a two's-complement value. All higher bits of that lane have no effect on the result.
- R3: A count above zero shifts the lane left. A count of zero or below shifts it right by the magnitude of the count, with no rounding. A right shift is arithmetic for signed lanes (`is_signed`=1) and logical for unsigned lanes. A right shift by the lane width or more gives all sign bits (signed) or zero (unsigned).
- R4: When a left-shifted value does not fit in its lane, the lane saturates. A signed lane goes to its most positive value if the input was non-negative and to its most negative value otherwise. An unsigned lane goes to all ones. For a left shift by the lane width or more, any nonzero input saturates and a zero input gives zero without saturating.
- R5: `sat_now` is high in the cycle after an accepted operation exactly when at least one processed lane saturated. Otherwise it is low.
- R6: `sat_sticky` is set by every accepted operation that saturates. It stays set until `flag_clr` is sampled high. If a clear and a saturating operation are sampled in the same cycle, the flag ends up set.
- R7: With `wide_sel`=1, a strobe where any of `idx_dst`, `idx_src_a`, `idx_src_b` has bit 0 set raises `out_undef` for one cycle. For that request `out_valid` and `sat_now` stay low, `result` keeps its previous value and `sat_sticky` is not set.
- R8: `out_valid` rises one cycle after an accepted strobe, and `result` takes the new value in that same cycle. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| wide_sel | input | 1 | 1: 128-bit form, 0: 64-bit form |
| lane_sz | input | 2 | Lane width code |
| is_signed | input | 1 | 1: signed lanes, 0: unsigned lanes |
| idx_dst | input | 5 | Destination register index of the request |
| idx_src_a | input | 5 | First source register index |
| idx_src_b | input | 5 | Second source register index |
| opnd_a | input | 128 | Vector whose lanes are shifted |
| opnd_b | input | 128 | Vector holding the per-lane shift counts |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| out_undef | output | 1 | The request was undefined |
| result | output | 128 | Shifted vector |
| sat_now | output | 1 | The last operation saturated a lane |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
The sticky flag has two causes that can land on the same edge: a clear request and a new saturation. The bench raises `flag_clr` at random and also in directed steps while a lane is driven into overflow. A behavioural model resolves every such collision in favour of the set and checks the flag on every clock. A second collision is an undefined wide request that would also have saturated. It is judged by confirming that `sat_now` and `sat_sticky` stay untouched while `out_undef` rises.

// File: rtl/lshift_pkg.sv
package lshift_pkg;

    localparam int IDX_W  = 5;
    localparam int CNT_W  = 8;
    localparam int NUM_SZ = 4;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic valid;
        logic undef;
        logic sat;
    } out_flags_t;

    // A wide request whose register indices are not all even is undefined.
    function automatic logic wide_req_bad(input logic wide,
                                          input logic [IDX_W-1:0] d,
                                          input logic [IDX_W-1:0] n,
                                          input logic [IDX_W-1:0] m);
        return wide & (d[0] | n[0] | m[0]);
    endfunction

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0]                  val_i,
    input  logic [lshift_pkg::CNT_W-1:0]  cnt_i,
    input  logic                          sgn_i,
    output logic [W-1:0]                  res_o,
    output logic                          sat_o
);
    localparam int CW = lshift_pkg::CNT_W;
    localparam logic [CW-1:0] W_CNT = CW'(W);

    logic           neg;
    logic [CW-1:0]  mag;
    logic [2*W-1:0] ext;
    logic [2*W-1:0] shl;
    logic [W:0]     top;
    logic           fits;
    logic [W-1:0]   clamp;

    always_comb begin
        neg   = sgn_i & val_i[W-1];
        ext   = {{W{neg}}, val_i};
        clamp = !sgn_i ? {W{1'b1}}
              : neg    ? {1'b1, {(W-1){1'b0}}}
                       : {1'b0, {(W-1){1'b1}}};
        shl   = '0;
        top   = '0;
        fits  = 1'b1;
        mag   = '0;
        res_o = val_i;
        sat_o = 1'b0;
        if (!cnt_i[CW-1] && cnt_i != '0) begin
            mag = cnt_i;
            if (mag >= W_CNT) begin
                fits  = (val_i == '0);
                res_o = fits ? '0 : clamp;
            end else begin
                shl  = ext << mag;
                top  = shl[2*W-1:W-1];
                fits = sgn_i ? ((&top) | ~(|top)) : (shl[2*W-1:W] == '0);
                res_o = fits ? shl[W-1:0] : clamp;
            end
            sat_o = !fits;
        end else begin
            mag = CW'(-cnt_i);
            if (mag >= W_CNT)
                res_o = {W{neg}};
            else if (sgn_i)
                res_o = W'($signed(val_i) >>> mag);
            else
                res_o = val_i >> mag;
        end
    end

    always_comb begin
        if (cnt_i == '0)
            AST_ZERO_COUNT_PASS: assert (res_o == val_i && !sat_o); // R3
    end

    always_comb begin
        if (sat_o === 1'b1)
            AST_SAT_VALUE: assert (sgn_i ? (res_o == {1'b1, {(W-1){1'b0}}} ||
                                           res_o == {1'b0, {(W-1){1'b1}}})
                                         : (res_o == {W{1'b1}})); // R4
    end

endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
    parameter int DATA_W = 128,
    parameter int LW     = 8
) (
    input  logic [DATA_W-1:0]    a_i,
    input  logic [DATA_W-1:0]    b_i,
    input  logic                 sgn_i,
    output logic [DATA_W-1:0]    res_o,
    output logic [DATA_W/LW-1:0] sat_o
);
    localparam int NL = DATA_W / LW;
    localparam int CW = lshift_pkg::CNT_W;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        lane_shifter #(.W(LW)) u_lane (
            .val_i (a_i[i*LW +: LW]),
            .cnt_i (b_i[i*LW +: CW]),
            .sgn_i (sgn_i),
            .res_o (res_o[i*LW +: LW]),
            .sat_o (sat_o[i])
        );
    end

endmodule

// File: rtl/vec_lane_qshift.sv
module vec_lane_qshift
    import lshift_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              wide_sel,
    input  logic [1:0]        lane_sz,
    input  logic              is_signed,
    input  logic [4:0]        idx_dst,
    input  logic [4:0]        idx_src_a,
    input  logic [4:0]        idx_src_b,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              flag_clr,
    output logic              out_valid,
    output logic              out_undef,
    output logic [DATA_W-1:0] result,
    output logic              sat_now,
    output logic              sat_sticky
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] res_sz [NUM_SZ];
    logic [NUM_SZ-1:0] sat_sz;

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
        localparam int LW  = 8 << k;
        localparam int NL  = DATA_W / LW;
        localparam int NLH = NL / 2;
        logic [NL-1:0] lane_sat;

        lane_bank #(.DATA_W(DATA_W), .LW(LW)) u_bank (
            .a_i   (opnd_a),
            .b_i   (opnd_b),
            .sgn_i (is_signed),
            .res_o (res_sz[k]),
            .sat_o (lane_sat)
        );

        assign sat_sz[k] = wide_sel ? (|lane_sat) : (|lane_sat[NLH-1:0]);
    end

    lane_sz_e          sz_sel;
    logic              bad_req;
    logic              accept;
    logic [DATA_W-1:0] res_pick;
    logic              sat_pick;
    out_flags_t        flags_d, flags_q;

    always_comb begin
        sz_sel   = lane_sz_e'(lane_sz);
        bad_req  = wide_req_bad(wide_sel, idx_dst, idx_src_a, idx_src_b);
        accept   = in_valid & ~bad_req;
        res_pick = res_sz[sz_sel] & {{HALF{wide_sel}}, {HALF{1'b1}}};
        sat_pick = sat_sz[sz_sel];
        flags_d.valid = accept;
        flags_d.undef = in_valid & bad_req;
        flags_d.sat   = accept & sat_pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            result     <= '0;
            sat_sticky <= 1'b0;
        end else begin
            flags_q    <= flags_d;
            sat_sticky <= (sat_sticky & ~flag_clr) | flags_d.sat;
            if (accept)
                result <= res_pick;
        end
    end

    assign out_valid = flags_q.valid;
    assign out_undef = flags_q.undef;
    assign sat_now   = flags_q.sat;

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(wide_sel && (idx_dst[0] || idx_src_a[0] || idx_src_b[0])))
        |=> out_valid && !out_undef); // R8

    AST_UNDEF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_sel && (idx_dst[0] || idx_src_a[0] || idx_src_b[0]))
        |=> out_undef && !out_valid && !sat_now && $stable(result)); // R7

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky && !flag_clr) |=> sat_sticky); // R6

    AST_STICKY_COVERS_NOW: assert property (@(posedge clk) disable iff (rst)
        sat_now |-> sat_sticky); // R6

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_sel) |=> (result[DATA_W-1:HALF] == '0)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_undef && !sat_now); // R5

endmodule

// File: tb/sim_vec_lane_qshift.sv
module sim_vec_lane_qshift;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, wide_sel, is_signed, flag_clr;
    logic [1:0]   lane_sz;
    logic [4:0]   idx_dst, idx_src_a, idx_src_b;
    logic [127:0] opnd_a, opnd_b;
    logic         out_valid, out_undef, sat_now, sat_sticky;
    logic [127:0] result;

    always #2 clk = ~clk;

    vec_lane_qshift u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_sel(wide_sel),
        .lane_sz(lane_sz), .is_signed(is_signed), .idx_dst(idx_dst),
        .idx_src_a(idx_src_a), .idx_src_b(idx_src_b), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .flag_clr(flag_clr), .out_valid(out_valid),
        .out_undef(out_undef), .result(result), .sat_now(sat_now),
        .sat_sticky(sat_sticky)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string res_tag = "R8";
    bit armed = 0;

    logic         e_valid, e_undef, e_sat, e_sticky;
    logic [127:0] e_res;

    // Behavioural model: each lane lifted into a wide signed integer and compared to its range.
    function automatic logic [127:0] model_vec(input logic [127:0] a, input logic [127:0] b,
                                               input int sz, input bit sgn, input bit wide,
                                               output bit any_sat);
        int w  = 8 << sz;
        int nl = (wide ? 128 : 64) / w;
        logic [127:0] out = '0;
        any_sat = 0;
        for (int i = 0; i < nl; i++) begin
            logic [127:0] ta = a >> (i * w);
            logic [127:0] tb = b >> (i * w);
            logic signed [199:0] msk = (200'sd1 <<< w) - 200'sd1;
            logic signed [199:0] v   = $signed({72'd0, ta}) & msk;
            logic signed [199:0] hi, lo, r;
            int c = int'($signed(tb[7:0]));
            if (sgn && ta[w-1]) v = v - (200'sd1 <<< w);
            hi = sgn ? (200'sd1 <<< (w - 1)) - 200'sd1 : msk;
            lo = sgn ? -(200'sd1 <<< (w - 1)) : 200'sd0;
            if (c > 0) begin
                r = v <<< c;
                if (r > hi) begin r = hi; any_sat = 1; end
                else if (r < lo) begin r = lo; any_sat = 1; end
            end else begin
                r = v >>> (-c);
            end
            out = out | (128'(r & msk) << (i * w));
        end
        return out;
    endfunction

    task automatic chk1(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        n_cmp++;
        if (result !== e_res) begin
            n_bad++;
            $display("FAIL %s result actual=%h expected=%h t=%0t", res_tag, result, e_res, $time);
        end
        chk1("R8", "out_valid", out_valid, e_valid);
        chk1("R7", "out_undef", out_undef, e_undef);
        chk1("R5", "sat_now", sat_now, e_sat);
        chk1("R6", "sat_sticky", sat_sticky, e_sticky);
    endtask

    // One clock: check the outputs from the previous step, then drive and predict.
    task automatic step(input bit r, input bit v, input bit wd, input int sz, input bit sg,
                        input logic [4:0] d, input logic [4:0] n, input logic [4:0] m,
                        input logic [127:0] a, input logic [127:0] b, input bit clr);
        bit s;
        bit bad;
        logic [127:0] rv;
        @(negedge clk);
        if (armed) compare_all();
        armed = 1;
        rst = r; in_valid = v; wide_sel = wd; lane_sz = 2'(sz); is_signed = sg;
        idx_dst = d; idx_src_a = n; idx_src_b = m; opnd_a = a; opnd_b = b; flag_clr = clr;
        if (r) begin
            e_valid = 0; e_undef = 0; e_sat = 0; e_sticky = 0; e_res = '0;
        end else begin
            bad = wd && (d[0] || n[0] || m[0]);
            rv  = model_vec(a, b, sz, sg, wd, s);
            e_valid  = v && !bad;
            e_undef  = v && bad;
            e_sat    = v && !bad && s;
            e_sticky = (e_sticky && !clr) || (v && !bad && s);
            if (v && !bad) e_res = rv;
        end
    endtask

    task automatic op(input bit wd, input int sz, input bit sg,
                      input logic [127:0] a, input logic [127:0] b, input bit clr);
        step(0, 1, wd, sz, sg, 5'd2, 5'd4, 5'd6, a, b, clr);
    endtask

    task automatic idle(input bit clr);
        step(0, 0, 0, 0, 0, 5'd0, 5'd0, 5'd0, '0, '0, clr);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        rst = 1; in_valid = 0; wide_sel = 0; lane_sz = 0; is_signed = 0; flag_clr = 0;
        idx_dst = 0; idx_src_a = 0; idx_src_b = 0; opnd_a = '0; opnd_b = '0;
        step(1, 0, 0, 0, 0, 0, 0, 0, '0, '0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, '0, '0, 0);
        res_tag = "R8";
        idle(0);                                   // R8: reset state observed here
        // R1: narrow form leaves upper half zero, wide form processes it
        res_tag = "R1";
        op(0, 0, 0, {128{1'b1}}, {16{8'h01}}, 0);
        op(1, 0, 0, {16{8'h03}}, {16{8'h01}}, 0);
        op(1, 3, 1, {64'h8000_0000_0000_0000, 64'd5}, {64'h0, 64'hFF}, 0);
        // R2: upper count bits ignored (16-bit lane count 0xAB01 means +1)
        res_tag = "R2";
        op(1, 1, 0, {8{16'h0011}}, {8{16'hAB01}}, 0);
        op(0, 2, 1, {2{32'h0000_0100}}, {2{32'h7FFF_FFFC}}, 0);
        // R3: right shifts, arithmetic vs logical, by lane width and beyond
        res_tag = "R3";
        op(1, 0, 1, {16{8'h80}}, {16{8'hFF}}, 0);
        op(1, 0, 0, {16{8'h80}}, {16{8'hFF}}, 0);
        op(1, 0, 1, {16{8'h90}}, {16{8'h80}}, 0);
        op(1, 1, 0, {8{16'hFFFF}}, {8{16'h00F0}}, 0);
        op(1, 3, 1, {2{64'hF000_0000_0000_0001}}, {2{64'h0000_0000_0000_00C0}}, 0);
        op(1, 2, 0, {4{32'h1234_5678}}, {4{32'h0}}, 0);
        // R4: saturation directions, huge left counts on zero and nonzero
        res_tag = "R4";
        op(1, 0, 1, {16{8'h40}}, {16{8'h01}}, 0);
        op(1, 0, 1, {16{8'hBF}}, {16{8'h01}}, 0);
        op(1, 0, 0, {16{8'h81}}, {16{8'h01}}, 0);
        op(1, 2, 1, {4{32'h0}}, {4{32'h0000_007F}}, 0);
        op(1, 3, 0, {64'h0, 64'h1}, {2{64'h40}}, 0);
        op(1, 3, 1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h3}, {64'h3F, 64'h3E}, 0);
        // R6: clear alone, then clear colliding with a saturating op
        res_tag = "R6";
        idle(1);
        idle(0);
        op(1, 0, 1, {16{8'h7F}}, {16{8'h01}}, 1);
        idle(0);
        idle(1);
        // R7: undefined wide request that would have saturated
        res_tag = "R7";
        step(0, 1, 1, 0, 1, 5'd3, 5'd4, 5'd6, {16{8'h7F}}, {16{8'h05}}, 0);
        step(0, 1, 1, 0, 1, 5'd2, 5'd4, 5'd7, {16{8'h7F}}, {16{8'h05}}, 0);
        step(0, 1, 0, 0, 1, 5'd3, 5'd5, 5'd7, {16{8'h01}}, {16{8'h01}}, 0);
        idle(0);
        // R3/R4/R5 under mixed random traffic
        res_tag = "R3";
        for (int k = 0; k < 3000; k++) begin
            logic [127:0] a, b;
            bit wd = ($urandom % 2) == 1;
            logic [4:0] d = 5'($urandom % 32);
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom % 3 == 0) a = a & {16{8'h07}};
            for (int j = 0; j < 16; j++)
                if ($urandom % 2 == 0) b[j*8 +: 8] = 8'(int'($urandom % 141) - 70);
            if ($urandom % 4 != 0) d[0] = 1'b0;
            step(0, ($urandom % 5) != 0, wd, int'($urandom % 4), ($urandom % 2) == 1,
                 d, 5'd4, 5'd8, a, b, ($urandom % 10) == 0);
        end
        idle(0);
        idle(0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule